// File: doc/BRIEF.md
# Set-Associative Write-Back Cache Controller

This block is a parameterised N-way set-associative data cache. It sits between a single-word processor request port and a slower memory port that moves whole blocks. Each word address is split into three fields. The lowest bits select a word inside a block, the next bits pick a set, and all remaining upper bits are the tag. A request is accepted, the indexed set is looked up in the following cycle, and a hit is answered in that same cycle.

On a miss the controller runs a multi-cycle sequence. It picks a victim way from a separate replacement unit. If the victim holds modified data, the victim is copied back to memory. The missing block is then fetched and installed, and the response is delivered.

Writes follow write-back with write-allocate. A write hit changes only the cached copy and marks the line dirty. A write miss first brings the block in and then merges the word. A single-cycle invalidate input clears every valid bit and leaves the tags and data in place. Setting the way count to 1 turns the block into a direct-mapped cache.

Top module: `cache_wb_ctrl`

## Requirements
- R1: Addresses are word addresses. The field `req_addr[OFF_W-1:0]` (OFF_W = log2(BLK_WORDS)) picks the word within a block. The next log2(SETS) bits are the set index, and all remaining upper bits are the tag. Every word of a block that has been filled hits.
- R2: A lookup hits only if some way of the indexed set is valid and holds the same tag as the address. After reset no line is valid, so the first access to any block misses.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. For a hit, `resp_valid` is high in the very next cycle and, for a read, `resp_rdata` carries the stored word. For a write, `resp_rdata` is undefined.
- R4: A read miss issues one memory read (`mem_req_we`=0) whose `mem_req_addr` is the block number `req_addr >> OFF_W`. The requested word is taken out of the returned block. The filled line is valid and clean.
- R5: A write hit updates only the cached word, sends nothing to memory and sets the line's dirty bit. A later read of that word returns the new value.
- R6: A write miss fetches the block from memory, installs it, and then writes the word into it. The other words of the block keep their memory values.
- R7: When the victim line is valid and dirty, it is sent to memory as one full block (`mem_req_we`=1) at its own block number, before the refill read. A clean or invalid victim causes no memory write.
- R8: The victim is the lowest-numbered invalid way of the set if there is one. Otherwise it is the least recently used way, where both hits and fills count as uses.
- R9: `req_ready` is low from acceptance until the response cycle, inclusive. Exactly one `resp_valid` cycle is produced per accepted request.
- R10: A cycle with `inv_all` high, while the controller is idle, clears all valid bits and holds `req_ready` low in that cycle. Dirty lines are dropped without any memory write, and later accesses to them miss.
- R11: With WAYS=1, each block maps to exactly one line. Two blocks that share an index evict each other, with write-back of dirty data.
- R12: A memory request holds `mem_req_valid`, `mem_req_we` and `mem_req_addr` steady until `mem_req_ready` is seen high. The read data is taken on the `mem_resp_valid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inv_all | input | 1 | Clear all valid bits (acted on while idle) |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Write data |
| resp_valid | output | 1 | Response cycle |
| resp_rdata | output | WORD_W | Read data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_req_addr | output | ADDR_W-OFF_W | Block number |
| mem_req_wdata | output | WORD_W*BLK_WORDS | Block written back |
| mem_resp_valid | input | 1 | Read block returned |
| mem_resp_rdata | input | WORD_W*BLK_WORDS | Returned block |

## Verification
The bench builds two copies side by side, each with 4 sets of 4-word blocks over a 10-bit address. One copy has 2 ways, which brings in invalid-first victim choice, LRU ordering after an intervening hit, and chains of dirty and clean evictions within a single set. The other copy has 1 way, which makes every same-index pair a conflict. That exposes the direct-mapped eviction and write-back path. The memory model raises its ready only every other cycle, so requests are held across stalls.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WRITEBACK,
        ST_REFILL,
        ST_RESPOND
    } cache_state_e;

endpackage

// File: rtl/cache_line_store.sv
module cache_line_store #(
    parameter int WAYS      = 4,
    parameter int SETS      = 16,
    parameter int TAG_W     = 10,
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 4,
    localparam int IDX_W    = $clog2(SETS),
    localparam int OFF_W    = $clog2(BLK_WORDS),
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int LINE_W   = WORD_W * BLK_WORDS
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [IDX_W-1:0]                 rd_idx,
    output logic [WAYS-1:0]                  rd_valid,
    output logic [WAYS-1:0]                  rd_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]       rd_tag,
    output logic [WAYS-1:0][LINE_W-1:0]      rd_line,
    input  logic                             clr_all,
    input  logic                             fill_en,
    input  logic [IDX_W-1:0]                 fill_idx,
    input  logic [WAY_W-1:0]                 fill_way,
    input  logic [TAG_W-1:0]                 fill_tag,
    input  logic [LINE_W-1:0]                fill_line,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [WAY_W-1:0]                 wr_way,
    input  logic [OFF_W-1:0]                 wr_off,
    input  logic [WORD_W-1:0]                wr_word
);

    logic [WAYS-1:0]   valid_q [SETS];
    logic [WAYS-1:0]   dirty_q [SETS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [LINE_W-1:0] line_q  [SETS][WAYS];

    // Read port: whole indexed set, combinational
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_dirty = dirty_q[rd_idx];
        for (int w = 0; w < WAYS; w++) begin
            rd_tag[w]  = tag_q[rd_idx][w];
            rd_line[w] = line_q[rd_idx][w];
        end
    end

    // Flag bits: reset and invalidate touch only these
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else if (clr_all) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
            end
        end else begin
            if (fill_en) begin
                valid_q[fill_idx][fill_way] <= 1'b1;
                dirty_q[fill_idx][fill_way] <= 1'b0;
            end
            if (wr_en) begin
                dirty_q[wr_idx][wr_way] <= 1'b1;
            end
        end
    end

    // Tag and data arrays: never cleared
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx][fill_way]  <= fill_tag;
            line_q[fill_idx][fill_way] <= fill_line;
        end
        if (wr_en) begin
            line_q[wr_idx][wr_way][wr_off*WORD_W +: WORD_W] <= wr_word;
        end
    end

endmodule

// File: rtl/cache_way_match.sv
module cache_way_match #(
    parameter int WAYS   = 4,
    parameter int TAG_W  = 10,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]           look_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);

    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = way_valid[g] && (way_tag[g] == look_tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/cache_repl_lru.sv
module cache_repl_lru #(
    parameter int WAYS   = 4,
    parameter int SETS   = 16,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [WAYS-1:0]  look_valid,
    output logic [WAY_W-1:0] victim,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [WAY_W-1:0] touch_way
);

    localparam logic [WAY_W-1:0] AGE_MAX = WAY_W'(WAYS - 1);

    // Age 0 = least recently used, AGE_MAX = most recently used
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAY_W-1:0] age_d [SETS][WAYS];
    logic [WAY_W-1:0] old_age;

    always_comb begin
        age_d   = age_q;
        old_age = age_q[touch_idx][touch_way];
        victim  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[look_idx][w] == '0) victim = WAY_W'(w);
        end
        // A free way wins over the LRU one; lowest number first
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!look_valid[w]) victim = WAY_W'(w);
        end
        if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_d[touch_idx][w] = AGE_MAX;
                end else if (age_q[touch_idx][w] > old_age) begin
                    age_d[touch_idx][w] = age_q[touch_idx][w] - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else begin
            age_q <= age_d;
        end
    end

endmodule

// File: rtl/cache_wb_ctrl.sv
module cache_wb_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 4,
    parameter int SETS      = 16,
    parameter int WAYS      = 4,
    localparam int OFF_W    = $clog2(BLK_WORDS),
    localparam int IDX_W    = $clog2(SETS),
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_W,
    localparam int BLK_AW   = ADDR_W - OFF_W,
    localparam int LINE_W   = WORD_W * BLK_WORDS,
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [BLK_AW-1:0] mem_req_addr,
    output logic [LINE_W-1:0] mem_req_wdata,
    input  logic              mem_resp_valid,
    input  logic [LINE_W-1:0] mem_resp_rdata
);

    typedef struct packed {
        cache_state_e      st;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
        logic [WAY_W-1:0]  way;
        logic              rd_sent;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [OFF_W-1:0] cur_off;
    logic [IDX_W-1:0] cur_idx;
    logic [TAG_W-1:0] cur_tag;

    logic [WAYS-1:0]              set_valid;
    logic [WAYS-1:0]              set_dirty;
    logic [WAYS-1:0][TAG_W-1:0]   set_tag;
    logic [WAYS-1:0][LINE_W-1:0]  set_line;
    logic                         hit;
    logic [WAY_W-1:0]             hit_way;
    logic [WAY_W-1:0]             victim;

    logic             clr_all;
    logic             fill_en;
    logic             wr_en;
    logic [WAY_W-1:0] wr_way;
    logic             touch_en;
    logic [WAY_W-1:0] touch_way;

    assign cur_off = ctl_q.addr[OFF_W-1:0];
    assign cur_idx = ctl_q.addr[OFF_W +: IDX_W];
    assign cur_tag = ctl_q.addr[ADDR_W-1 -: TAG_W];

    cache_line_store #(
        .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W),
        .WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (cur_idx),
        .rd_valid  (set_valid),
        .rd_dirty  (set_dirty),
        .rd_tag    (set_tag),
        .rd_line   (set_line),
        .clr_all   (clr_all),
        .fill_en   (fill_en),
        .fill_idx  (cur_idx),
        .fill_way  (ctl_q.way),
        .fill_tag  (cur_tag),
        .fill_line (mem_resp_rdata),
        .wr_en     (wr_en),
        .wr_idx    (cur_idx),
        .wr_way    (wr_way),
        .wr_off    (cur_off),
        .wr_word   (ctl_q.wdata)
    );

    cache_way_match #(
        .WAYS(WAYS), .TAG_W(TAG_W)
    ) u_match (
        .way_valid (set_valid),
        .way_tag   (set_tag),
        .look_tag  (cur_tag),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    cache_repl_lru #(
        .WAYS(WAYS), .SETS(SETS)
    ) u_repl (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_idx   (cur_idx),
        .look_valid (set_valid),
        .victim     (victim),
        .touch_en   (touch_en),
        .touch_idx  (cur_idx),
        .touch_way  (touch_way)
    );

    always_comb begin
        ctl_d         = ctl_q;
        req_ready     = 1'b0;
        resp_valid    = 1'b0;
        resp_rdata    = '0;
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = ctl_q.addr[ADDR_W-1:OFF_W];
        mem_req_wdata = set_line[ctl_q.way];
        clr_all       = 1'b0;
        fill_en       = 1'b0;
        wr_en         = 1'b0;
        wr_way        = ctl_q.way;
        touch_en      = 1'b0;
        touch_way     = ctl_q.way;

        unique case (ctl_q.st)
            ST_IDLE: begin
                req_ready = !inv_all;
                if (inv_all) begin
                    clr_all = 1'b1;
                end else if (req_valid) begin
                    ctl_d.st    = ST_LOOKUP;
                    ctl_d.we    = req_we;
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                end
            end
            ST_LOOKUP: begin
                if (hit) begin
                    resp_valid = 1'b1;
                    resp_rdata = set_line[hit_way][cur_off*WORD_W +: WORD_W];
                    wr_en      = ctl_q.we;
                    wr_way     = hit_way;
                    touch_en   = 1'b1;
                    touch_way  = hit_way;
                    ctl_d.st   = ST_IDLE;
                end else begin
                    ctl_d.way     = victim;
                    ctl_d.rd_sent = 1'b0;
                    if (set_valid[victim] && set_dirty[victim]) begin
                        ctl_d.st = ST_WRITEBACK;
                    end else begin
                        ctl_d.st = ST_REFILL;
                    end
                end
            end
            ST_WRITEBACK: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = {set_tag[ctl_q.way], cur_idx};
                if (mem_req_ready) ctl_d.st = ST_REFILL;
            end
            ST_REFILL: begin
                mem_req_valid = !ctl_q.rd_sent;
                if (!ctl_q.rd_sent && mem_req_ready) begin
                    ctl_d.rd_sent = 1'b1;
                end
                if (ctl_q.rd_sent && mem_resp_valid) begin
                    fill_en  = 1'b1;
                    ctl_d.st = ST_RESPOND;
                end
            end
            ST_RESPOND: begin
                resp_valid = 1'b1;
                resp_rdata = set_line[ctl_q.way][cur_off*WORD_W +: WORD_W];
                wr_en      = ctl_q.we;
                touch_en   = 1'b1;
                ctl_d.st   = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/cache_wb_ctrl_chk.sv
module cache_wb_ctrl_chk #(
    parameter int BLK_AW = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_we,
    input logic [BLK_AW-1:0] mem_req_addr
);

    // R9: no acceptance possible in a response cycle
    a_r9_resp_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    // R9: one response cycle per request
    a_r9_single_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R3/R9: acceptance is followed by a busy cycle
    a_r3_accept_then_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R12: stalled memory request keeps its content
    a_r12_mem_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr)));

    // R7: write-back happens inside the miss sequence, never with a response
    a_r7_wb_not_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> (!resp_valid && !req_ready));

endmodule

bind cache_wb_ctrl cache_wb_ctrl_chk #(.BLK_AW(BLK_AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/cache_wb_ctrl_bench.sv
`timescale 1ns/1ps

module cache_mem_model #(
    parameter int BLK_AW    = 8,
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 4,
    parameter int LAT       = 3,
    localparam int LINE_W   = WORD_W * BLK_WORDS,
    localparam int OFF_W    = $clog2(BLK_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [BLK_AW-1:0] req_addr,
    input  logic [LINE_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [LINE_W-1:0] resp_rdata,
    output logic [31:0]       wr_count,
    output logic [31:0]       rd_count,
    output logic [BLK_AW-1:0] last_rd_addr
);

    logic [LINE_W-1:0] mem [2**BLK_AW];
    logic [7:0]        cnt;

    function automatic logic [WORD_W-1:0] init_word(int a);
        return WORD_W'(32'hC0DE0000 + a * 7);
    endfunction

    assign resp_valid = (cnt == 8'd1);
    assign resp_rdata = mem[last_rd_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < 2**BLK_AW; b++) begin
                for (int w = 0; w < BLK_WORDS; w++) begin
                    mem[b][w*WORD_W +: WORD_W] <= init_word((b << OFF_W) + w);
                end
            end
            req_ready    <= 1'b0;
            cnt          <= '0;
            wr_count     <= '0;
            rd_count     <= '0;
            last_rd_addr <= '0;
        end else begin
            req_ready <= !req_ready;
            if (cnt != 0) cnt <= cnt - 1'b1;
            if (req_valid && req_ready) begin
                if (req_we) begin
                    mem[req_addr] <= req_wdata;
                    wr_count      <= wr_count + 1;
                end else begin
                    last_rd_addr <= req_addr;
                    rd_count     <= rd_count + 1;
                    cnt          <= 8'(LAT);
                end
            end
        end
    end

endmodule

module cache_wb_ctrl_bench;

    localparam int ADDR_W    = 10;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 4;
    localparam int SETS      = 4;
    localparam int OFF_W     = $clog2(BLK_WORDS);
    localparam int BLK_AW    = ADDR_W - OFF_W;
    localparam int LINE_W    = WORD_W * BLK_WORDS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              inv_all   [2];
    logic              req_valid [2];
    logic              req_ready [2];
    logic              req_we    [2];
    logic [ADDR_W-1:0] req_addr  [2];
    logic [WORD_W-1:0] req_wdata [2];
    logic              resp_valid[2];
    logic [WORD_W-1:0] resp_rdata[2];
    logic              mreq_valid[2];
    logic              mreq_ready[2];
    logic              mreq_we   [2];
    logic [BLK_AW-1:0] mreq_addr [2];
    logic [LINE_W-1:0] mreq_wdata[2];
    logic              mresp_valid[2];
    logic [LINE_W-1:0] mresp_rdata[2];
    logic [31:0]       wr_cnt    [2];
    logic [31:0]       rd_cnt    [2];
    logic [BLK_AW-1:0] last_rd   [2];

    // Instance 0: 2 ways, instance 1: direct-mapped
    for (genvar g = 0; g < 2; g++) begin : g_sys
        cache_wb_ctrl #(
            .ADDR_W(ADDR_W), .WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS),
            .SETS(SETS), .WAYS((g == 0) ? 2 : 1)
        ) u_cache_wb_ctrl (
            .clk            (clk),
            .rst_n          (rst_n),
            .inv_all        (inv_all[g]),
            .req_valid      (req_valid[g]),
            .req_ready      (req_ready[g]),
            .req_we         (req_we[g]),
            .req_addr       (req_addr[g]),
            .req_wdata      (req_wdata[g]),
            .resp_valid     (resp_valid[g]),
            .resp_rdata     (resp_rdata[g]),
            .mem_req_valid  (mreq_valid[g]),
            .mem_req_ready  (mreq_ready[g]),
            .mem_req_we     (mreq_we[g]),
            .mem_req_addr   (mreq_addr[g]),
            .mem_req_wdata  (mreq_wdata[g]),
            .mem_resp_valid (mresp_valid[g]),
            .mem_resp_rdata (mresp_rdata[g])
        );

        cache_mem_model #(
            .BLK_AW(BLK_AW), .WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS), .LAT(3)
        ) u_mem (
            .clk          (clk),
            .rst_n        (rst_n),
            .req_valid    (mreq_valid[g]),
            .req_ready    (mreq_ready[g]),
            .req_we       (mreq_we[g]),
            .req_addr     (mreq_addr[g]),
            .req_wdata    (mreq_wdata[g]),
            .resp_valid   (mresp_valid[g]),
            .resp_rdata   (mresp_rdata[g]),
            .wr_count     (wr_cnt[g]),
            .rd_count     (rd_cnt[g]),
            .last_rd_addr (last_rd[g])
        );
    end

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    function automatic logic [WORD_W-1:0] iw(int a);
        return WORD_W'(32'hC0DE0000 + a * 7);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One processor access with hit/miss timing, data and ready checks
    task automatic acc(input int sel, input bit we, input int addr,
                       input logic [WORD_W-1:0] wdata, input logic [WORD_W-1:0] exp,
                       input bit exp_hit, input string req);
        int cyc;
        bit busy_ok;
        @(negedge clk);
        while (!req_ready[sel]) @(negedge clk);
        req_valid[sel] = 1'b1;
        req_we[sel]    = we;
        req_addr[sel]  = ADDR_W'(addr);
        req_wdata[sel] = wdata;
        @(posedge clk);
        @(negedge clk);
        req_valid[sel] = 1'b0;
        cyc     = 1;
        busy_ok = 1'b1;
        while (!resp_valid[sel] && cyc < 500) begin
            if (req_ready[sel]) busy_ok = 1'b0;
            @(negedge clk);
            cyc++;
        end
        if (req_ready[sel]) busy_ok = 1'b0;
        check(busy_ok, "R9", $sformatf("ready low while busy @%0h", addr), 64'(busy_ok), 64'd1);
        if (exp_hit)
            check(cyc == 1, req, $sformatf("hit latency @%0h", addr), 64'(cyc), 64'd1);
        else
            check(cyc > 1 && cyc < 500, req, $sformatf("miss latency @%0h", addr), 64'(cyc), 64'd2);
        if (!we)
            check(resp_rdata[sel] == exp, req, $sformatf("read data @%0h", addr),
                  64'(resp_rdata[sel]), 64'(exp));
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(req_ready[0] && req_ready[1], "R2", "ready after reset", 64'(req_ready[0]), 64'd1);
        check(!resp_valid[0] && !mreq_valid[0], "R9", "idle outputs after reset",
              64'({resp_valid[0], mreq_valid[0]}), 64'd0);
    endtask

    task automatic t_read_miss_and_fields;
        acc(0, 0, 'h040, 0, iw('h040), 0, "R2");
        check(rd_cnt[0] == 1, "R4", "one block read", 64'(rd_cnt[0]), 64'd1);
        check(last_rd[0] == BLK_AW'('h10), "R4", "aligned block number", 64'(last_rd[0]), 64'h10);
        acc(0, 0, 'h043, 0, iw('h043), 1, "R1");
        acc(0, 0, 'h041, 0, iw('h041), 1, "R3");
        acc(0, 0, 'h044, 0, iw('h044), 0, "R1");
    endtask

    task automatic t_write_hit;
        logic [31:0] wc;
        wc = wr_cnt[0];
        acc(0, 1, 'h041, 32'hDEAD0001, 0, 1, "R5");
        acc(0, 0, 'h041, 0, 32'hDEAD0001, 1, "R5");
        check(wr_cnt[0] == wc, "R5", "no memory write on write hit", 64'(wr_cnt[0]), 64'(wc));
    endtask

    task automatic t_write_miss;
        acc(0, 1, 'h082, 32'hBEEF0002, 0, 0, "R6");
        check(rd_cnt[0] == 3, "R6", "write miss fetched block", 64'(rd_cnt[0]), 64'd3);
        acc(0, 0, 'h082, 0, 32'hBEEF0002, 1, "R6");
        acc(0, 0, 'h083, 0, iw('h083), 1, "R6");
    endtask

    task automatic t_evictions;
        acc(0, 0, 'h100, 0, iw('h100), 0, "R7");
        check(wr_cnt[0] == 1, "R7", "dirty victim written", 64'(wr_cnt[0]), 64'd1);
        check(g_sys[0].u_mem.mem['h10][63:32] == 32'hDEAD0001, "R7", "written block content",
              64'(g_sys[0].u_mem.mem['h10][63:32]), 64'hDEAD0001);
        acc(0, 0, 'h041, 0, 32'hDEAD0001, 0, "R7");
        check(wr_cnt[0] == 2, "R7", "second dirty victim", 64'(wr_cnt[0]), 64'd2);
        check(g_sys[0].u_mem.mem['h20][95:64] == 32'hBEEF0002, "R7", "second block content",
              64'(g_sys[0].u_mem.mem['h20][95:64]), 64'hBEEF0002);
        acc(0, 0, 'h180, 0, iw('h180), 0, "R7");
        check(wr_cnt[0] == 2, "R7", "clean victim dropped", 64'(wr_cnt[0]), 64'd2);
    endtask

    task automatic t_lru;
        acc(0, 0, 'h008, 0, iw('h008), 0, "R8");
        acc(0, 0, 'h018, 0, iw('h018), 0, "R8");
        acc(0, 0, 'h008, 0, iw('h008), 1, "R8");
        acc(0, 0, 'h028, 0, iw('h028), 0, "R8");
        acc(0, 0, 'h008, 0, iw('h008), 1, "R8");
        acc(0, 0, 'h018, 0, iw('h018), 0, "R8");
    endtask

    task automatic t_invalidate;
        logic [31:0] wc;
        acc(0, 1, 'h009, 32'h11112222, 0, 1, "R10");
        wc = wr_cnt[0];
        @(negedge clk);
        inv_all[0] = 1'b1;
        #1;
        check(!req_ready[0], "R10", "ready low during invalidate", 64'(req_ready[0]), 64'd0);
        @(negedge clk);
        inv_all[0] = 1'b0;
        acc(0, 0, 'h009, 0, iw('h009), 0, "R10");
        check(wr_cnt[0] == wc, "R10", "dirty line dropped silently", 64'(wr_cnt[0]), 64'(wc));
        acc(0, 0, 'h041, 0, 32'hDEAD0001, 0, "R10");
    endtask

    task automatic t_direct_mapped;
        acc(1, 0, 'h040, 0, iw('h040), 0, "R11");
        acc(1, 0, 'h041, 0, iw('h041), 1, "R11");
        acc(1, 1, 'h041, 32'h5A5A0041, 0, 1, "R11");
        acc(1, 0, 'h080, 0, iw('h080), 0, "R11");
        check(wr_cnt[1] == 1, "R11", "conflict write-back", 64'(wr_cnt[1]), 64'd1);
        acc(1, 0, 'h041, 0, 32'h5A5A0041, 0, "R11");
        acc(1, 0, 'h080, 0, iw('h080), 0, "R11");
        check(wr_cnt[1] == 1, "R11", "clean conflict eviction", 64'(wr_cnt[1]), 64'd1);
        check(rd_cnt[1] == 4, "R12", "one read per miss", 64'(rd_cnt[1]), 64'd4);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            inv_all[i]   = 1'b0;
            req_valid[i] = 1'b0;
            req_we[i]    = 1'b0;
            req_addr[i]  = '0;
            req_wdata[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_miss_and_fields();
        t_write_hit();
        t_write_miss();
        t_evictions();
        t_lru();
        t_invalidate();
        t_direct_mapped();
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule